// File: doc/BRIEF.md
# Floating-Point Status Condition-Code Generator

This block keeps the condition-code byte of a 32-bit floating-point status word. A producer hands it each new result as a sign bit, an exponent field and a fraction field, with a format select for single, double or extended precision. The block sorts the result into a class and stores only that class: positive finite, negative finite, zero, positive infinity, negative infinity or not-a-number. The read port assembles the condition bits from the stored class on every cycle.

A host can also write the whole status word. The low 24 bits are kept as written. The condition bits of a written word are not stored as raw bits. They are decoded into one of the stored classes, and later reads are built from that class. Result updates use a valid/ready handshake. The host write, the read and the format select are plain control pins.

Back-pressure rule: `upd_ready` is low in any cycle where `wr_en` is high. A producer that holds `upd_valid` must keep its fields stable until it sees `upd_valid && upd_ready` at a rising edge. `upd_ready` is high in every other cycle.

Top module: `fp_status_cc`

## Requirements
- R1: `upd_fmt` selects the field widths. Code 0 is single: exponent bits 7..0 and fraction bits 22..0. Code 1 is double: exponent bits 10..0 and fraction bits 51..0. Codes 2 and 3 are extended: exponent bits 14..0 and fraction bits 63..0. Input bits above the selected widths have no effect on the class.
- R2: A result whose exponent and fraction are both zero reads back with bit 26 (zero) set and bits 27, 25 and 24 clear, whatever its sign.
- R3: A result with an all-ones exponent and a zero fraction sets bit 25 (infinity). Bit 27 (negative) is also set when the sign is 1. Bits 26 and 24 stay clear.
- R4: A result with an all-ones exponent and a nonzero fraction sets bit 24 (not-a-number) only, whatever its sign. Bits 25, 26 and 27 stay clear.
- R5: Any other result, including one with a zero exponent and a nonzero fraction, sets bit 27 equal to its sign and clears bits 26, 25 and 24.
- R6: `rd_data` is the stored bits 23..0, ORed with the condition bits of the stored class in bits 27..24. Bits 31..28 always read 0. A result update leaves bits 23..0 unchanged.
- R7: A host write stores `wr_data[23:0]` and picks the class by priority. Bit 24 set gives not-a-number. Otherwise bit 26 set gives zero. Otherwise bit 27 set gives negative finite. Otherwise the class is positive finite. Bits 25 and 31..28 of the written word have no effect.
- R8: When `upd_valid && upd_ready` is high at a rising edge, the new class appears in `rd_data` after that edge. A host write likewise appears in `rd_data` after the edge that samples it.
- R9: When `wr_en` and `upd_valid` are both high in one cycle, `upd_ready` is low and the write takes effect. An update that is held valid is then accepted in the next cycle that has no write.
- R10: After reset the class is positive finite and the stored low bits are zero, so `rd_data` reads 0.
- R11: In a cycle with no write and no accepted update, `rd_data` stays unchanged, whatever the values on the result fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Result update offered |
| upd_ready | output | 1 | Update accepted in this cycle (low while a host write is present) |
| upd_fmt | input | 2 | Format code: 0 single, 1 double, 2 or 3 extended |
| upd_sign | input | 1 | Result sign |
| upd_exp | input | 15 | Result exponent, right-aligned |
| upd_frac | input | 64 | Result fraction, right-aligned |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| rd_data | output | 32 | Status word: stored low 24 bits plus condition bits |

## Verification
A host write and a result update can arrive in the same cycle. The bench provokes this by raising `wr_en` and `upd_valid` together. It then checks that `upd_ready` is low in that cycle and that the next read shows the written class. It keeps `upd_valid` high into the following cycle and expects the read after that to show the update's class. The low bits stay as written throughout. The checker also watches this collision on every cycle of the run.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int NFMT   = 3;
  localparam int LOW_W  = 24;
  localparam int CC_NAN = 24;
  localparam int CC_INF = 25;
  localparam int CC_ZRO = 26;
  localparam int CC_NEG = 27;

  typedef enum logic [2:0] {
    CLS_POS  = 3'd0,
    CLS_NEG  = 3'd1,
    CLS_ZERO = 3'd2,
    CLS_INFP = 3'd3,
    CLS_INFN = 3'd4,
    CLS_NAN  = 3'd5
  } res_cls_e;

  function automatic int fmt_exp_w(input int idx);
    case (idx)
      0:       return 8;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int idx);
    case (idx)
      0:       return 23;
      1:       return 52;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/fpcc_field_classify.sv
module fpcc_field_classify
  import fpcc_pkg::*;
#(
  parameter int EXP_IN_W  = 15,
  parameter int FRAC_IN_W = 64,
  parameter int EW        = 8,
  parameter int FW        = 23
) (
  input  logic                 sign_i,
  input  logic [EXP_IN_W-1:0]  exp_i,
  input  logic [FRAC_IN_W-1:0] frac_i,
  output res_cls_e             cls_o
);

  localparam logic [EXP_IN_W-1:0]  EMASK = {EXP_IN_W{1'b1}} >> (EXP_IN_W - EW);
  localparam logic [FRAC_IN_W-1:0] FMASK = {FRAC_IN_W{1'b1}} >> (FRAC_IN_W - FW);

  logic [EXP_IN_W-1:0]  exp_sel;
  logic [FRAC_IN_W-1:0] frac_sel;
  logic exp_max, exp_nil, frac_nil;

  assign exp_sel  = exp_i & EMASK;
  assign frac_sel = frac_i & FMASK;
  assign exp_max  = (exp_sel == EMASK);
  assign exp_nil  = (exp_sel == '0);
  assign frac_nil = (frac_sel == '0);

  always_comb begin
    if (exp_max && !frac_nil)     cls_o = CLS_NAN;
    else if (exp_max)             cls_o = sign_i ? CLS_INFN : CLS_INFP;
    else if (exp_nil && frac_nil) cls_o = CLS_ZERO;
    else                          cls_o = sign_i ? CLS_NEG : CLS_POS;
  end

endmodule

// File: rtl/fpcc_class_reg.sv
module fpcc_class_reg
  import fpcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_fire,
  input  res_cls_e         upd_cls,
  input  logic             wr_en,
  input  logic [LOW_W-1:0] wr_low,
  input  logic             wr_nan,
  input  logic             wr_zero,
  input  logic             wr_neg,
  output res_cls_e         cls_q,
  output logic [LOW_W-1:0] low_q
);

  res_cls_e wr_cls;

  always_comb begin
    if (wr_nan)       wr_cls = CLS_NAN;
    else if (wr_zero) wr_cls = CLS_ZERO;
    else if (wr_neg)  wr_cls = CLS_NEG;
    else              wr_cls = CLS_POS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q <= CLS_POS;
      low_q <= '0;
    end else if (wr_en) begin
      cls_q <= wr_cls;
      low_q <= wr_low;
    end else if (upd_fire) begin
      cls_q <= upd_cls;
    end
  end

endmodule

// File: rtl/fpcc_read_mux.sv
module fpcc_read_mux
  import fpcc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  res_cls_e          cls_i,
  input  logic [LOW_W-1:0]  low_i,
  output logic [WORD_W-1:0] word_o
);

  logic [3:0] cc;

  always_comb begin
    cc = 4'b0000;
    case (cls_i)
      CLS_NAN:  cc[CC_NAN-LOW_W] = 1'b1;
      CLS_ZERO: cc[CC_ZRO-LOW_W] = 1'b1;
      CLS_NEG:  cc[CC_NEG-LOW_W] = 1'b1;
      CLS_INFP: cc[CC_INF-LOW_W] = 1'b1;
      CLS_INFN: begin
        cc[CC_INF-LOW_W] = 1'b1;
        cc[CC_NEG-LOW_W] = 1'b1;
      end
      default:  cc = 4'b0000;
    endcase
    word_o = '0;
    word_o[LOW_W-1:0]     = low_i;
    word_o[LOW_W+3:LOW_W] = cc;
  end

endmodule

// File: rtl/fp_status_cc.sv
module fp_status_cc
  import fpcc_pkg::*;
#(
  parameter int EXP_IN_W  = 15,
  parameter int FRAC_IN_W = 64,
  parameter int WORD_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [1:0]           upd_fmt,
  input  logic                 upd_sign,
  input  logic [EXP_IN_W-1:0]  upd_exp,
  input  logic [FRAC_IN_W-1:0] upd_frac,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [WORD_W-1:0]    rd_data
);

  res_cls_e fmt_cls [NFMT];
  res_cls_e sel_cls;
  res_cls_e cls_q;
  logic [LOW_W-1:0] low_q;
  logic upd_fire;

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    fpcc_field_classify #(
      .EXP_IN_W (EXP_IN_W),
      .FRAC_IN_W(FRAC_IN_W),
      .EW       (fmt_exp_w(g)),
      .FW       (fmt_frac_w(g))
    ) u_cls (
      .sign_i(upd_sign),
      .exp_i (upd_exp),
      .frac_i(upd_frac),
      .cls_o (fmt_cls[g])
    );
  end

  always_comb begin
    case (upd_fmt)
      2'd0:    sel_cls = fmt_cls[0];
      2'd1:    sel_cls = fmt_cls[1];
      default: sel_cls = fmt_cls[2];
    endcase
  end

  assign upd_ready = !wr_en;
  assign upd_fire  = upd_valid && upd_ready;

  fpcc_class_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_fire(upd_fire),
    .upd_cls (sel_cls),
    .wr_en   (wr_en),
    .wr_low  (wr_data[LOW_W-1:0]),
    .wr_nan  (wr_data[CC_NAN]),
    .wr_zero (wr_data[CC_ZRO]),
    .wr_neg  (wr_data[CC_NEG]),
    .cls_q   (cls_q),
    .low_q   (low_q)
  );

  fpcc_read_mux #(.WORD_W(WORD_W)) u_mux (
    .cls_i (cls_q),
    .low_i (low_q),
    .word_o(rd_data)
  );

endmodule

// File: rtl/fp_status_cc_chk.sv
module fp_status_cc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_valid,
  input logic        upd_ready,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data
);

  // R4: not-a-number excludes the other condition bits
  assert_nan_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[24] |-> (rd_data[27:25] == 3'b000));

  // R2: zero never reads as negative or infinite
  assert_zero_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[26] |-> (rd_data[27] == 1'b0 && rd_data[25] == 1'b0));

  // R6: top nibble always reads zero
  assert_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:28] == 4'h0);

  // R7: the written low bits appear on the next read
  assert_low_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[23:0] == $past(wr_data[23:0])));

  // R7: bit 25 and bits 31..28 of a written word have no effect
  assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[24] && !wr_data[26] && !wr_data[27] &&
     (wr_data[25] || (wr_data[31:28] != 4'h0))) |=> (rd_data[31:24] == 8'h00));

  // R9: a host write blocks a result update
  assert_wr_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !upd_ready);

  // R11: no write and no offer means the read stays stable
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_valid) |=> $stable(rd_data));

endmodule

bind fp_status_cc fp_status_cc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_valid(upd_valid),
  .upd_ready(upd_ready),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data)
);

// File: tb/fp_status_cc_test.sv
`timescale 1ns/1ps
module fp_status_cc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [1:0]  upd_fmt = '0;
  logic        upd_sign = 1'b0;
  logic [14:0] upd_exp = '0;
  logic [63:0] upd_frac = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [23:0] cur_low = '0;
  logic [31:0] last_exp = '0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_item_t;
  exp_item_t sb[$];

  always #2 clk = ~clk;

  fp_status_cc uut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_fmt(upd_fmt), .upd_sign(upd_sign), .upd_exp(upd_exp), .upd_frac(upd_frac),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // class codes used by the bench: 0 pos, 1 neg, 2 zero, 3 +inf, 4 -inf, 5 nan
  function automatic int bench_cls(input logic [1:0] f, input logic s,
                                   input logic [14:0] e, input logic [63:0] m);
    int ew, fw;
    logic [14:0] em, es;
    logic [63:0] fm, fs;
    ew = (f == 2'd0) ? 8 : (f == 2'd1) ? 11 : 15;
    fw = (f == 2'd0) ? 23 : (f == 2'd1) ? 52 : 64;
    em = 15'h7FFF >> (15 - ew);
    fm = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - fw);
    es = e & em;
    fs = m & fm;
    if (es == em && fs != 0) return 5;
    if (es == em)            return s ? 4 : 3;
    if (es == 0 && fs == 0)  return 2;
    return s ? 1 : 0;
  endfunction

  function automatic logic [31:0] word_of(input logic [23:0] low, input int c);
    logic [3:0] cc;
    case (c)
      1: cc = 4'b1000;
      2: cc = 4'b0100;
      3: cc = 4'b0010;
      4: cc = 4'b1010;
      5: cc = 4'b0001;
      default: cc = 4'b0000;
    endcase
    return {4'h0, cc, low};
  endfunction

  function automatic int wr_cls(input logic [31:0] w);
    if (w[24]) return 5;
    if (w[26]) return 2;
    if (w[27]) return 1;
    return 0;
  endfunction

  task automatic push(input logic [31:0] v, input string tag);
    exp_item_t it;
    it.val = v;
    it.tag = tag;
    sb.push_back(it);
    last_exp = v;
  endtask

  task automatic do_upd(input logic [1:0] f, input logic s, input logic [14:0] e,
                        input logic [63:0] m, input string tag);
    @(negedge clk);
    upd_valid = 1'b1; upd_fmt = f; upd_sign = s; upd_exp = e; upd_frac = m;
    @(posedge clk);
    #1 upd_valid = 1'b0;
    push(word_of(cur_low, bench_cls(f, s, e, m)), tag);
  endtask

  task automatic do_wr(input logic [31:0] w, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(posedge clk);
    #1 wr_en = 1'b0;
    cur_low = w[23:0];
    push(word_of(cur_low, wr_cls(w)), tag);
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    upd_fmt = 2'd2; upd_sign = 1'b1; upd_exp = 15'h7FFF; upd_frac = 64'h1;
    @(posedge clk);
    #1 push(last_exp, tag);
  endtask

  task automatic do_both(input logic [31:0] w, input logic [1:0] f, input logic s,
                         input logic [14:0] e, input logic [63:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    upd_valid = 1'b1; upd_fmt = f; upd_sign = s; upd_exp = e; upd_frac = m;
    #1;
    checks++;
    if (upd_ready !== 1'b0) begin
      errors++;
      $display("FAIL R9 upd_ready during write: actual=%b expected=0", upd_ready);
    end
    @(posedge clk);
    #1 wr_en = 1'b0;
    cur_low = w[23:0];
    push(word_of(cur_low, wr_cls(w)), "R9 write wins");
    @(posedge clk);
    #1 upd_valid = 1'b0;
    push(word_of(cur_low, bench_cls(f, s, e, m)), "R9 held update");
  endtask

  // monitor: compare the read word against the scoreboard away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_item_t it;
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.val) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, rd_data, it.val);
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push(32'h0, "R10 reset state");
    @(posedge clk);
    do_upd(2'd0, 1'b0, 15'h00FF, 64'h1, "R4 single nan");
    do_upd(2'd0, 1'b0, 15'h00FF, 64'h0, "R3 single +inf");
    do_upd(2'd0, 1'b1, 15'h7FFF, 64'hFFFF_FFFF_FF80_0000, "R1 single upper bits ignored");
    do_upd(2'd1, 1'b1, 15'h0000, 64'h0, "R2 negative zero");
    do_upd(2'd1, 1'b1, 15'h03FF, 64'h5, "R5 double negative");
    do_upd(2'd2, 1'b0, 15'h0000, 64'h1, "R5 extended denormal");
    do_upd(2'd2, 1'b1, 15'h7FFF, 64'h0, "R3 extended -inf");
    do_upd(2'd3, 1'b1, 15'h7FFF, 64'h8000_0000_0000_0000, "R4 code3 nan");
    do_upd(2'd1, 1'b0, 15'h07FF, 64'h0010_0000_0000_0000, "R1 double frac above width");
    do_upd(2'd1, 1'b0, 15'h07FF, 64'h0008_0000_0000_0000, "R1 double nan");
    do_wr(32'h0F00_00AB, "R7 write nan priority");
    do_wr(32'h0C12_3456, "R7 write zero");
    do_wr(32'h0800_0001, "R7 write negative");
    do_wr(32'h0200_0000, "R7 bit25 ignored");
    do_wr(32'hF000_0010, "R7 top bits ignored");
    do_upd(2'd0, 1'b1, 15'h0080, 64'h0, "R6 low bits kept on update");
    do_upd(2'd0, 1'b0, 15'h00FF, 64'h3, "R8 update latency");
    do_idle("R11 idle stable");
    do_both(32'h0455_AA00, 2'd2, 1'b1, 15'h7FFF, 64'h0);
    do_idle("R11 idle after collision");
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule